// File: doc/BRIEF.md
# Colour-state controller with a flashing state

This block is a four-state Moore machine that turns a two-bit push-button code into a six-bit LED colour word. Three of the states each show one fixed colour. The fourth state, the flash state, alternates between a mark colour and a configurable space colour. A phase bit sets which of the two is shown. A counter times the phase bit, and the mark and space phases have separate lengths.

The phase logic runs only while the machine is in the flash state. It is forced back to the start of the space phase on the cycle the machine leaves that state. Each visit to the flash state therefore begins in the same way. By default the two phase lengths split one second of the `CLK_HZ` clock. A user can give the lengths in cycles directly, for example to get a faster blink or to run a short simulation.

Top module: `led_mode_fsm`

## Requirements
- R1: While `rst_ni` is low the machine is in the home state and `led_o` is 6'b111111. This takes effect without waiting for a clock edge. The phase bit and the phase counter are cleared at the same time.
- R2: The steady colours are as follows. The home state shows 6'b111111. The state reached by button code 2'b01 from the flash state shows 6'b100010. The state reached by button code 2'b10 from the flash state shows 6'b110110.
- R3: The transitions are:
  - home goes to flash on 2'b01;
  - flash goes to the 2'b01 state on 2'b01 and to the 2'b10 state on 2'b10;
  - either of those two states goes back to home on 2'b10.

  Every other button code, including 2'b00 and 2'b11, keeps the current state.
- R4: In the flash state `led_o` is 6'b010100 during the mark phase and `ALT_CODE` during the space phase.
- R5: In the flash state the space phase lasts exactly `OFF_CYCLES` clock cycles and the mark phase lasts exactly `ON_CYCLES` clock cycles. The two phases alternate for as long as the state is held.
- R6: Every entry into the flash state begins with a full space phase, starting on the first cycle in that state. This holds no matter where the previous visit ended.
- R7: The phase counter and phase bit do not change outside the flash state. A leaving button code in the flash state clears both on that edge.
- R8: `led_o` depends only on the registered state and the phase bit. A change of `btn_i` between clock edges does not change `led_o` until the next edge.
- R9: With only `CLK_HZ` given, the sum of the mark and space lengths is `CLK_HZ` cycles, which is a one-second blink period. The space phase gets the larger half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 2 | Button code: 2'b01 and 2'b10 act, 2'b00 and 2'b11 do nothing |
| led_o | output | 6 | LED colour word |

## Verification
The main sequence drives every button code in every state. This separates the codes that must move the machine from the codes that must leave it alone, 2'b11 in particular. It holds the flash state long enough to see several complete space and mark phases of unequal length, so swapped or off-by-one limits show up. It also leaves the flash state both from the space phase and from the mark phase, and re-enters it each time, which tells a cleared phase from a phase left over from the last visit. A second instance built from `CLK_HZ` alone is held in the flash state for two full periods to confirm the default split.

// File: rtl/led_fsm_pkg.sv
package led_fsm_pkg;

   localparam int LED_W = 6;
   localparam int BTN_W = 2;

   typedef enum logic [1:0] {
      ST_HOME  = 2'd0,
      ST_FLASH = 2'd1,
      ST_LEFT  = 2'd2,
      ST_RIGHT = 2'd3
   } led_state_e;

   localparam logic [BTN_W-1:0] BTN_A = 2'b01;
   localparam logic [BTN_W-1:0] BTN_B = 2'b10;

   localparam logic [LED_W-1:0] CODE_HOME  = 6'b111111;
   localparam logic [LED_W-1:0] CODE_MARK  = 6'b010100;
   localparam logic [LED_W-1:0] CODE_LEFT  = 6'b100010;
   localparam logic [LED_W-1:0] CODE_RIGHT = 6'b110110;

endpackage

// File: rtl/led_mode_state.sv
module led_mode_state
   import led_fsm_pkg::*;
(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [BTN_W-1:0] btn_i,
   output led_state_e       state_o,
   output logic             leave_o
);

   led_state_e state_q, state_d;
   logic       press_a, press_b;

   assign press_a = (btn_i == BTN_A);
   assign press_b = (btn_i == BTN_B);

   // leaving condition of the flash state, shared with the phase timer
   assign leave_o = (state_q == ST_FLASH) && (press_a || press_b);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_HOME:  if (press_a) state_d = ST_FLASH;
         ST_FLASH: begin
            if (press_a)      state_d = ST_LEFT;
            else if (press_b) state_d = ST_RIGHT;
         end
         ST_LEFT:  if (press_b) state_d = ST_HOME;
         ST_RIGHT: if (press_b) state_d = ST_HOME;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= ST_HOME;
      else         state_q <= state_d;
   end

   assign state_o = state_q;

endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
   parameter int ON_CYCLES  = 2,
   parameter int OFF_CYCLES = 2,
   parameter int CNT_W      = 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             leave_i,
   output logic             phase_o,
   output logic [CNT_W-1:0] cnt_o
);

   localparam int MAX_CYC = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES;

   logic phase_q;

   generate
      if (MAX_CYC == 1) begin : g_toggle
         // both phases one cycle long: no counter needed
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                 phase_q <= 1'b0;
            else if (run_i && leave_i)   phase_q <= 1'b0;
            else if (run_i)              phase_q <= ~phase_q;
         end
         assign cnt_o = '0;
      end else begin : g_count
         localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(ON_CYCLES - 1);
         localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(OFF_CYCLES - 1);

         logic [CNT_W-1:0] cnt_q;
         logic [CNT_W-1:0] lim;

         assign lim = phase_q ? HI_LIM : LO_LIM;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cnt_q   <= '0;
               phase_q <= 1'b0;
            end else if (run_i && leave_i) begin
               cnt_q   <= '0;
               phase_q <= 1'b0;
            end else if (run_i) begin
               if (cnt_q == lim) begin
                  cnt_q   <= '0;
                  phase_q <= ~phase_q;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
         end
         assign cnt_o = cnt_q;
      end
   endgenerate

   assign phase_o = phase_q;

endmodule

// File: rtl/led_code_map.sv
module led_code_map
   import led_fsm_pkg::*;
#(
   parameter logic [LED_W-1:0] ALT_CODE = '0
) (
   input  led_state_e       state_i,
   input  logic             phase_i,
   output logic [LED_W-1:0] led_o
);

   always_comb begin
      unique case (state_i)
         ST_HOME:  led_o = CODE_HOME;
         ST_FLASH: led_o = phase_i ? CODE_MARK : ALT_CODE;
         ST_LEFT:  led_o = CODE_LEFT;
         ST_RIGHT: led_o = CODE_RIGHT;
      endcase
   end

endmodule

// File: rtl/led_mode_fsm.sv
module led_mode_fsm
   import led_fsm_pkg::*;
#(
   parameter int               CLK_HZ     = 125_000_000,
   parameter int               ON_CYCLES  = CLK_HZ / 2,
   parameter int               OFF_CYCLES = CLK_HZ - CLK_HZ / 2,
   parameter logic [LED_W-1:0] ALT_CODE   = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [BTN_W-1:0] btn_i,
   output logic [LED_W-1:0] led_o
);

   localparam int MAX_CYC = (ON_CYCLES > OFF_CYCLES) ? ON_CYCLES : OFF_CYCLES;
   localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

   generate
      if (CLK_HZ < 2) begin : g_bad_clk
         $error("led_mode_fsm: CLK_HZ must be at least 2");
      end
      if (ON_CYCLES < 1) begin : g_bad_on
         $error("led_mode_fsm: ON_CYCLES must be at least 1");
      end
      if (OFF_CYCLES < 1) begin : g_bad_off
         $error("led_mode_fsm: OFF_CYCLES must be at least 1");
      end
   endgenerate

   led_state_e       state_q;
   logic             leave_w;
   logic             phase_q;
   logic [CNT_W-1:0] cnt_q;

   led_mode_state u_state (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .btn_i   (btn_i),
      .state_o (state_q),
      .leave_o (leave_w)
   );

   led_blink_timer #(
      .ON_CYCLES  (ON_CYCLES),
      .OFF_CYCLES (OFF_CYCLES),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .run_i   (state_q == ST_FLASH),
      .leave_i (leave_w),
      .phase_o (phase_q),
      .cnt_o   (cnt_q)
   );

   led_code_map #(
      .ALT_CODE (ALT_CODE)
   ) u_map (
      .state_i (state_q),
      .phase_i (phase_q),
      .led_o   (led_o)
   );

endmodule

// File: rtl/led_mode_fsm_chk.sv
module led_mode_fsm_chk
   import led_fsm_pkg::*;
#(
   parameter int               ON_CYCLES  = 2,
   parameter int               OFF_CYCLES = 2,
   parameter logic [LED_W-1:0] ALT_CODE   = '0,
   parameter int               CNT_W      = 1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [BTN_W-1:0] btn_i,
   input logic [LED_W-1:0] led_o,
   input led_state_e       state_q,
   input logic             phase_q,
   input logic [CNT_W-1:0] cnt_q
);

   // R1
   rst_home_chk: assert property (@(posedge clk_i)
      !rst_ni |-> led_o == CODE_HOME);

   // R3
   go_flash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HOME && btn_i == BTN_A) |=> state_q == ST_FLASH);

   // R3
   hold_home_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HOME && btn_i != BTN_A) |=> state_q == ST_HOME);

   // R2
   left_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q == ST_LEFT |-> led_o == CODE_LEFT);

   // R5
   cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_q ? (int'(cnt_q) < ON_CYCLES) : (int'(cnt_q) < OFF_CYCLES));

   // R6
   entry_space_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_HOME && btn_i == BTN_A) |=> led_o == ALT_CODE);

   // R7
   idle_timer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      state_q != ST_FLASH |=> ($stable(cnt_q) && $stable(phase_q)));

   // R7
   leave_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_FLASH && (btn_i == BTN_A || btn_i == BTN_B))
      |=> (cnt_q == '0 && !phase_q));

endmodule

bind led_mode_fsm led_mode_fsm_chk #(
   .ON_CYCLES  (ON_CYCLES),
   .OFF_CYCLES (OFF_CYCLES),
   .ALT_CODE   (ALT_CODE),
   .CNT_W      (CNT_W)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .btn_i   (btn_i),
   .led_o   (led_o),
   .state_q (state_q),
   .phase_q (phase_q),
   .cnt_q   (cnt_q)
);

// File: tb/led_mode_fsm_tb_top.sv
module led_mode_fsm_tb_top;

   localparam logic [5:0] ALT  = 6'b001001;
   localparam logic [5:0] HOME = 6'b111111;
   localparam logic [5:0] MARK = 6'b010100;
   localparam logic [5:0] LEFT = 6'b100010;
   localparam logic [5:0] RGHT = 6'b110110;
   localparam int         NVEC = 25;

   // {button, expected led after the edge}; ON=3, OFF=2
   localparam logic [7:0] VEC [NVEC] = '{
      {2'b00, HOME},  // R2 home
      {2'b10, HOME},  // R3 no move
      {2'b11, HOME},  // R3 no move
      {2'b01, ALT },  // R3 to flash, R6 space first
      {2'b00, ALT },  // R5 space 2 cycles
      {2'b00, MARK},  // R4 mark
      {2'b00, MARK},
      {2'b00, MARK},  // R5 mark 3 cycles
      {2'b00, ALT },
      {2'b11, ALT },  // R3 11 holds flash
      {2'b00, MARK},
      {2'b00, MARK},
      {2'b10, RGHT},  // R3 leave from mark, R2
      {2'b01, RGHT},  // R3 holds
      {2'b10, HOME},
      {2'b01, ALT },  // R6 restart, R7
      {2'b00, ALT },
      {2'b00, MARK},
      {2'b01, LEFT},  // R3 leave to left, R2
      {2'b01, LEFT},
      {2'b00, LEFT},
      {2'b10, HOME},
      {2'b01, ALT },  // R7 cleared
      {2'b01, LEFT},  // R3 leave on first cycle
      {2'b10, HOME}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] btn = 2'b00;
   logic [1:0] btn_hz = 2'b00;
   logic [5:0] led;
   logic [5:0] led_hz;
   int         n_chk = 0;
   int         n_bad = 0;

   always #4 clk = ~clk;

   led_mode_fsm #(
      .CLK_HZ     (125_000_000),
      .ON_CYCLES  (3),
      .OFF_CYCLES (2),
      .ALT_CODE   (ALT)
   ) dut_i (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .btn_i  (btn),
      .led_o  (led)
   );

   led_mode_fsm #(
      .CLK_HZ (10)
   ) dut_hz_i (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .btn_i  (btn_hz),
      .led_o  (led_hz)
   );

   task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: led=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic apply(input logic [1:0] b, input logic [5:0] exp, input string tag);
      @(negedge clk);
      btn = b;
      @(posedge clk);
      #2;
      check(tag, led, exp);
   endtask

   initial begin
      #3;
      check("R1 during reset", led, HOME);
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++)
         apply(VEC[i][7:6], VEC[i][5:0], $sformatf("R2,R3,R4,R5,R6,R7 vector %0d", i));

      // R8: button change between edges leaves led alone
      @(negedge clk);
      btn = 2'b01;
      #1;
      check("R8 home before edge", led, HOME);
      @(posedge clk);
      #2;
      check("R6 entry space", led, ALT);
      apply(2'b00, ALT, "R5 space second cycle");
      apply(2'b00, MARK, "R4 mark");
      // R1: asynchronous reset in the mark phase
      #1;
      rst_n = 1'b0;
      #1;
      check("R1 async reset", led, HOME);
      @(negedge clk);
      rst_n = 1'b1;
      apply(2'b00, HOME, "R1 home after reset");
      apply(2'b01, ALT, "R1 phase cleared by reset");
      apply(2'b10, RGHT, "R3 flash to right");
      apply(2'b10, HOME, "R3 right to home");

      // R9: default split of CLK_HZ = 10 cycles
      @(negedge clk);
      btn_hz = 2'b01;
      @(posedge clk);
      #2;
      btn_hz = 2'b00;
      for (int i = 0; i < 20; i++) begin
         if (i > 0) begin
            @(posedge clk);
            #2;
         end
         check($sformatf("R9 period cycle %0d", i), led_hz,
               ((i % 10) < 5) ? 6'b000000 : MARK);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule